// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block carries out the entry into a trap for a 32-bit processor with windowed registers. A request carries an 8-bit trap type along with a snapshot of the processor state: the trap-enable bit, the supervisor bit, the previous-supervisor bit, the current window pointer, PC, next PC, the base field of the trap base register, and a cache control word. When the request is accepted, the block uses one busy cycle to present the updated state. In that cycle it also raises strobes that save the old PC and old next PC into two local registers of the new window. For external interrupts it raises an acknowledge with the interrupt level and writes a cache control word in which enabled caches may be frozen.

If a trap arrives while traps are disabled, the block does not take it. It stops in an error state. The one exception is trap type 0x80 with the shutdown option enabled, which gives a shutdown request instead. Only reset leaves either final state.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset all outputs are 0. The block is idle, not halted and not shut down.
- R2: A request seen at a clock edge while idle with `et_i`=1 gives exactly one busy cycle after that edge. A request held high during the busy cycle is ignored.
- R3: In the busy cycle, `et_o`=0, `sup_o`=1 and `psup_o` equals the `sup_i` value that came with the request.
- R4: In the busy cycle, `cwp_o` is the request's window pointer minus one, wrapping from 0 to NWIN-1.
- R5: In the busy cycle, `tbr_o` holds the request's base field in bits [31:12], the trap type in bits [11:4] and zeros in bits [3:0]. `pc_o` equals `tbr_o` and `npc_o` equals `tbr_o`+4.
- R6: In the busy cycle, `save_we_o`=1 and `save_win_o` equals `cwp_o`. `save_pc_o` and `save_npc_o` carry the request's PC and next PC, which are stored to local 1 and local 2 of that window.
- R7: `ack_o` pulses in the busy cycle only for trap types 0x11 to 0x1F, and `ack_level_o` then equals the low nibble of the trap type.
- R8: The cache control word has the instruction cache state in bits [1:0], the data cache state in [3:2], the instruction freeze enable in bit 4 and the data freeze enable in bit 5. State codes are 00 off, 01 frozen and 11 on. On an acknowledged interrupt, a state of 11 whose freeze enable is 1 becomes 01, and every other field is copied unchanged. `ccw_we_o` equals `ack_o`. On any other entry, `ccw_o` equals `ccw_i`.
- R9: A request with `et_i`=0 gives no busy cycle and sets `halted_o`. A request with `et_i`=0 also sets `halted_o` for trap type 0x80 when `shutdown_en_i`=0.
- R10: A request with `et_i`=0, trap type 0x80 and `shutdown_en_i`=1 sets `shutdown_o` and leaves `halted_o` at 0.
- R11: Once halted or shut down, the block ignores further requests and stays in that state until reset. No busy cycle occurs, and the state outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Trap request |
| trap_type_i | input | 8 | Trap type |
| shutdown_en_i | input | 1 | Enables shutdown on trap 0x80 when traps are disabled |
| et_i | input | 1 | Trap-enable bit |
| sup_i | input | 1 | Supervisor bit |
| psup_i | input | 1 | Previous-supervisor bit (not used by entry) |
| cwp_i | input | 3 | Current window pointer |
| pc_i | input | 32 | PC |
| npc_i | input | 32 | Next PC |
| tbr_base_i | input | 20 | Trap base field |
| ccw_i | input | 6 | Cache control word |
| busy_o | output | 1 | Entry cycle |
| et_o | output | 1 | Updated trap-enable bit |
| sup_o | output | 1 | Updated supervisor bit |
| psup_o | output | 1 | Updated previous-supervisor bit |
| cwp_o | output | 3 | Updated window pointer |
| pc_o | output | 32 | New PC |
| npc_o | output | 32 | New next PC |
| tbr_o | output | 32 | New trap base register |
| save_we_o | output | 1 | Window save strobe |
| save_win_o | output | 3 | Window written |
| save_pc_o | output | 32 | Data for local 1 |
| save_npc_o | output | 32 | Data for local 2 |
| ack_o | output | 1 | Interrupt acknowledge |
| ack_level_o | output | 4 | Acknowledged level |
| ccw_we_o | output | 1 | Cache control write strobe |
| ccw_o | output | 6 | Updated cache control word |
| halted_o | output | 1 | Error state |
| shutdown_o | output | 1 | Shutdown request |

## Verification
The sweep covers every one of the 256 trap types with traps enabled. Each type is paired with a different window pointer, supervisor bit and cache control pattern, so the wrap at window 0 is seen. The sweep also separates the interrupt group from its neighbours 0x10 and 0x20, and reaches every combination of cache state and freeze bit. A request held high over two cycles shows that the busy cycle is not repeated. Separate runs cover the disabled-trap cases: type 0x80 with shutdown enabled, type 0x80 with shutdown disabled, and type 0x81 with shutdown enabled. They tell the shutdown path from the error path and show that requests made afterwards are ignored.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int TT_W = 8;
  localparam logic [3:0] EXT_IRQ_GRP = 4'h1;
  localparam logic [TT_W-1:0] SHUTDOWN_TT = 8'h80;

  typedef enum logic [1:0] {
    CST_OFF    = 2'b00,
    CST_FROZEN = 2'b01,
    CST_RSVD   = 2'b10,
    CST_ON     = 2'b11
  } cache_st_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ENTRY,
    SEQ_HALT,
    SEQ_DOWN
  } seq_st_e;
endpackage

// File: rtl/trap_win_dec.sv
module trap_win_dec #(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input  logic [CWP_W-1:0] cwp_i,
  output logic [CWP_W-1:0] cwp_o
);
  localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);
  localparam logic [CWP_W-1:0] TOP = CWP_W'(NWIN - 1);

  generate
    if (POW2) begin : g_pow2
      assign cwp_o = cwp_i - 1'b1;
    end else begin : g_wrap
      assign cwp_o = (cwp_i == '0) ? TOP : cwp_i - 1'b1;
    end
  endgenerate
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-13:0] base_i,
  input  logic [TT_W-1:0]  tt_i,
  output logic [XLEN-1:0]  tbr_o,
  output logic [XLEN-1:0]  npc_o
);
  assign tbr_o = {base_i, tt_i, 4'h0};
  assign npc_o = tbr_o + XLEN'(4);
endmodule

// File: rtl/trap_cache_freeze.sv
module trap_cache_freeze
  import trap_seq_pkg::*;
#(
  parameter int NCACHE = 2,
  parameter int CCW_W  = 3 * NCACHE
) (
  input  logic             irq_i,
  input  logic [CCW_W-1:0] ccw_i,
  output logic [CCW_W-1:0] ccw_o
);
  // layout: states at [2k+1:2k], freeze enables at [2*NCACHE+k]
  generate
    for (genvar k = 0; k < NCACHE; k++) begin : g_cache
      logic [1:0] st;
      logic       frz;
      assign st  = ccw_i[2*k +: 2];
      assign frz = ccw_i[2*NCACHE + k];
      assign ccw_o[2*k +: 2] = (irq_i && frz && st == CST_ON) ? CST_FROZEN : st;
      assign ccw_o[2*NCACHE + k] = frz;
    end
  endgenerate
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int XLEN   = 32,
  parameter int NCACHE = 2,
  parameter int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
  parameter int CCW_W  = 3 * NCACHE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trap_req_i,
  input  logic [TT_W-1:0]     trap_type_i,
  input  logic                shutdown_en_i,
  input  logic                et_i,
  input  logic                sup_i,
  input  logic                psup_i,
  input  logic [CWP_W-1:0]    cwp_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [XLEN-1:0]     npc_i,
  input  logic [XLEN-13:0]    tbr_base_i,
  input  logic [CCW_W-1:0]    ccw_i,
  output logic                busy_o,
  output logic                et_o,
  output logic                sup_o,
  output logic                psup_o,
  output logic [CWP_W-1:0]    cwp_o,
  output logic [XLEN-1:0]     pc_o,
  output logic [XLEN-1:0]     npc_o,
  output logic [XLEN-1:0]     tbr_o,
  output logic                save_we_o,
  output logic [CWP_W-1:0]    save_win_o,
  output logic [XLEN-1:0]     save_pc_o,
  output logic [XLEN-1:0]     save_npc_o,
  output logic                ack_o,
  output logic [3:0]          ack_level_o,
  output logic                ccw_we_o,
  output logic [CCW_W-1:0]    ccw_o,
  output logic                halted_o,
  output logic                shutdown_o
);
  seq_st_e st_q, st_d;

  logic [CWP_W-1:0] cwp_nxt;
  logic [XLEN-1:0]  tbr_nxt, npc_nxt;
  logic [CCW_W-1:0] ccw_nxt;
  logic             is_irq, take, psup_unused;

  assign psup_unused = psup_i; // old previous-supervisor bit is overwritten
  assign is_irq = (trap_type_i[7:4] == EXT_IRQ_GRP) && (trap_type_i[3:0] != 4'h0);
  assign take   = (st_q == SEQ_IDLE) && trap_req_i && et_i;

  trap_win_dec #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
    .cwp_i (cwp_i),
    .cwp_o (cwp_nxt)
  );

  trap_vec_gen #(.XLEN(XLEN)) u_vec (
    .base_i (tbr_base_i),
    .tt_i   (trap_type_i),
    .tbr_o  (tbr_nxt),
    .npc_o  (npc_nxt)
  );

  trap_cache_freeze #(.NCACHE(NCACHE), .CCW_W(CCW_W)) u_frz (
    .irq_i (is_irq),
    .ccw_i (ccw_i),
    .ccw_o (ccw_nxt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (trap_req_i) begin
        if (et_i)                                              st_d = SEQ_ENTRY;
        else if (shutdown_en_i && trap_type_i == SHUTDOWN_TT)  st_d = SEQ_DOWN;
        else                                                   st_d = SEQ_HALT;
      end
      SEQ_ENTRY: st_d = SEQ_IDLE;
      default:   st_d = st_q;
    endcase
  end

  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SEQ_IDLE;
      et_o        <= 1'b0;
      sup_o       <= 1'b0;
      psup_o      <= 1'b0;
      cwp_o       <= '0;
      pc_o        <= '0;
      npc_o       <= '0;
      tbr_o       <= '0;
      save_pc_o   <= '0;
      save_npc_o  <= '0;
      ack_q       <= 1'b0;
      ack_level_o <= '0;
      ccw_o       <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        et_o        <= 1'b0;
        psup_o      <= sup_i;
        sup_o       <= 1'b1;
        cwp_o       <= cwp_nxt;
        tbr_o       <= tbr_nxt;
        pc_o        <= tbr_nxt;
        npc_o       <= npc_nxt;
        save_pc_o   <= pc_i;
        save_npc_o  <= npc_i;
        ack_q       <= is_irq;
        ack_level_o <= is_irq ? trap_type_i[3:0] : 4'h0;
        ccw_o       <= ccw_nxt;
      end
    end
  end

  assign busy_o     = (st_q == SEQ_ENTRY);
  assign save_we_o  = busy_o;
  assign save_win_o = cwp_o;
  assign ack_o      = busy_o && ack_q;
  assign ccw_we_o   = ack_o;
  assign halted_o   = (st_q == SEQ_HALT);
  assign shutdown_o = (st_q == SEQ_DOWN);
endmodule

module trap_entry_seq_chk #(
  parameter int NWIN  = 8,
  parameter int XLEN  = 32,
  parameter int CWP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sup_i,
  input logic [CWP_W-1:0] cwp_i,
  input logic             busy_o,
  input logic             et_o,
  input logic             sup_o,
  input logic             psup_o,
  input logic [CWP_W-1:0] cwp_o,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  npc_o,
  input logic [XLEN-1:0]  tbr_o,
  input logic             ack_o,
  input logic [3:0]       ack_level_o,
  input logic             halted_o,
  input logic             shutdown_o
);
  // R2
  single_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  // R3
  psr_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!et_o && sup_o && psup_o == $past(sup_i)));
  // R4
  win_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cwp_o == (($past(cwp_i) == '0) ? CWP_W'(NWIN - 1) : $past(cwp_i) - 1'b1)));
  // R5
  vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pc_o == tbr_o && npc_o == pc_o + XLEN'(4) && tbr_o[3:0] == 4'h0));
  // R7
  ack_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (busy_o && ack_level_o != 4'h0));
  // R11
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !busy_o));
  // R11
  down_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> (shutdown_o && !busy_o && !halted_o));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.NWIN(NWIN), .XLEN(XLEN), .CWP_W(CWP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sup_i       (sup_i),
  .cwp_i       (cwp_i),
  .busy_o      (busy_o),
  .et_o        (et_o),
  .sup_o       (sup_o),
  .psup_o      (psup_o),
  .cwp_o       (cwp_o),
  .pc_o        (pc_o),
  .npc_o       (npc_o),
  .tbr_o       (tbr_o),
  .ack_o       (ack_o),
  .ack_level_o (ack_level_o),
  .halted_o    (halted_o),
  .shutdown_o  (shutdown_o)
);

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        trap_req_i = 1'b0, shutdown_en_i = 1'b0, et_i = 1'b0, sup_i = 1'b0, psup_i = 1'b0;
  logic [7:0]  trap_type_i = '0;
  logic [2:0]  cwp_i = '0;
  logic [31:0] pc_i = '0, npc_i = '0;
  logic [19:0] tbr_base_i = '0;
  logic [5:0]  ccw_i = '0;
  logic        busy_o, et_o, sup_o, psup_o, save_we_o, ack_o, ccw_we_o, halted_o, shutdown_o;
  logic [2:0]  cwp_o, save_win_o;
  logic [31:0] pc_o, npc_o, tbr_o, save_pc_o, save_npc_o;
  logic [3:0]  ack_level_o;
  logic [5:0]  ccw_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trap_entry_seq #(.NWIN(NWIN)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] frz(input logic [1:0] st, input logic en, input logic irq);
    return (irq && en && st == 2'b11) ? 2'b01 : st;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    trap_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // drives a request for one cycle; returns at the negedge where busy should be high
  task automatic issue(input logic [7:0] tt, input logic et, input logic sd);
    @(negedge clk_i);
    trap_type_i = tt;
    et_i = et;
    shutdown_en_i = sd;
    trap_req_i = 1'b1;
    @(negedge clk_i);
    trap_req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 busy", busy_o, 0);
    chk("R1 state", {et_o, sup_o, psup_o, cwp_o}, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 flags", {save_we_o, ack_o, ccw_we_o, halted_o, shutdown_o}, 0);

    for (int t = 0; t < 256; t++) begin
      logic [7:0] tt;
      logic irq;
      logic [31:0] etbr;
      logic [5:0] eccw;
      tt = 8'(t);
      cwp_i = 3'(t * 3);
      sup_i = t[1];
      psup_i = ~t[1];
      pc_i = 32'h4000_0000 + 32'(t) * 8;
      npc_i = pc_i + 32'h24;
      tbr_base_i = 20'h5A5A5 ^ 20'(t * 7);
      ccw_i = 6'(t * 5 + (t >> 3));
      irq = (tt[7:4] == 4'h1) && (tt[3:0] != 4'h0);
      etbr = {tbr_base_i, tt, 4'h0};
      eccw = {ccw_i[5:4], frz(ccw_i[3:2], ccw_i[5], irq), frz(ccw_i[1:0], ccw_i[4], irq)};
      issue(tt, 1'b1, t[0]);
      chk("R2 busy", busy_o, 1);
      chk("R3 psr", {et_o, sup_o, psup_o}, {29'd0, 1'b0, 1'b1, sup_i});
      chk("R4 cwp", cwp_o, (cwp_i == 0) ? 3'(NWIN - 1) : cwp_i - 3'd1);
      chk("R5 tbr", tbr_o, etbr);
      chk("R5 pc", pc_o, etbr);
      chk("R5 npc", npc_o, etbr + 32'd4);
      chk("R6 we/win", {save_we_o, save_win_o}, {1'b1, cwp_o});
      chk("R6 pc save", save_pc_o, pc_i);
      chk("R6 npc save", save_npc_o, npc_i);
      chk("R7 ack", {ack_o, ack_level_o}, irq ? {1'b1, tt[3:0]} : 5'd0);
      chk("R8 ccw", {ccw_we_o, ccw_o}, {irq, eccw});
      @(negedge clk_i);
      chk("R2 busy end", {busy_o, save_we_o, ack_o}, 0);
    end

    // R2 held request during busy is ignored
    @(negedge clk_i);
    trap_type_i = 8'h05; et_i = 1'b1; trap_req_i = 1'b1;
    @(negedge clk_i);
    chk("R2 held busy", busy_o, 1);
    @(negedge clk_i);
    trap_req_i = 1'b0;
    chk("R2 held ignored", busy_o, 0);

    // R10 shutdown
    do_reset();
    issue(8'h80, 1'b0, 1'b1);
    chk("R10 shutdown", {shutdown_o, halted_o, busy_o}, 3'b100);
    issue(8'h12, 1'b1, 1'b0);
    chk("R11 down ignores", {shutdown_o, busy_o, ack_o}, 3'b100);
    chk("R11 down state", {et_o, sup_o, cwp_o}, 0);

    // R9 0x80 without shutdown enable
    do_reset();
    issue(8'h80, 1'b0, 1'b0);
    chk("R9 halt 0x80", {halted_o, shutdown_o, busy_o}, 3'b100);

    // R9 other type with enable set
    do_reset();
    issue(8'h81, 1'b0, 1'b1);
    chk("R9 halt 0x81", {halted_o, shutdown_o, busy_o}, 3'b100);
    issue(8'h13, 1'b1, 1'b0);
    chk("R11 halt ignores", {halted_o, busy_o, save_we_o}, 3'b100);
    chk("R11 halt state", pc_o, 0);
    do_reset();
    chk("R11 reset clears", {halted_o, shutdown_o}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule